// File: doc/BRIEF.md
# Embedded Interval and Watchdog Timer Unit

This unit gives a processor core three timers that share one free-running time base. The time base advances once for each cycle in which the tick enable is high. A fixed interval timer posts status on a selectable edge of the time base. A programmable down-counter works in one-shot or periodic mode. A watchdog escalates through three stages on a selectable edge: it first arms, then interrupts, and then requests a core, chip or system reset.

Software sees the unit through three 32-bit registers on a simple write/read port. The control register is selected by index 0, the status register by index 1 and the counter by index 2. Reads are combinational. Status bits are cleared by writing ones to them. Interrupt requests are level outputs that stay high until software withdraws them. Reset requests are single-cycle pulses for an external reset controller.

Parameters set the time-base width and the counter width. They also set the base tap bit of each period selector and the tap spacing. A selector value `s` picks time-base bit `BASE + STEP*s`.

Top module: `emb_timer_unit`

## Requirements
- R1: After reset, all three registers read 0 and all six request outputs are low.
- R2: A control write keeps only bits 31:22 and forces bits 21:0 to zero. The control fields are: watchdog period select 31:30, watchdog reset kind 29:28, watchdog interrupt enable 27, counter interrupt enable 26, interval period select 25:24, interval interrupt enable 23, counter auto-reload 22.
- R3: A status write clears each of bits 31, 30, 27 and 26 that is written as one. Status bits 29:28 (latched reset kind) cannot be cleared by a write, and once they are non-zero they keep their value until unit reset.
- R4: A tick that makes the interval-selected time-base bit rise from 0 to 1 sets status bit 26. If control bit 23 is set, it also raises `fit_irq`. `fit_irq` drops when status bit 26 is written as one.
- R5: A counter write loads both the reload value and the count. The counter runs only if the written value is greater than 1 and control bit 26 is set; otherwise it holds the written count. A read at index 2 returns the current count.
- R6: While running, the count drops by one per tick. A tick at count 1 is an expiry: it sets status bit 27 and, if control bit 26 is set, raises `pit_irq`.
- R7: At expiry with control bit 22 set, the count returns to the reload value and the counter keeps running. With bit 22 clear, the count becomes 0 and the counter stops.
- R8: `pit_irq` drops only when status bit 31 is written as one. Clearing status bit 27 alone leaves `pit_irq` high.
- R9: A control write stops the counter, holding its count, if the reload value is at most 1 or the new bit 26 is clear. If the counter is stopped, the reload value is above 1, and the new bits 26 and 22 are both set, the write restarts it from the reload value.
- R10: On a watchdog event with status bits 31 and 30 both clear, the unit sets bit 31. With bit 31 set and bit 30 clear, it sets bit 30 and, if control bit 27 is set, raises `wdt_irq`. `wdt_irq` drops when status bit 30 is written as one.
- R11: On a watchdog event with status bit 30 set, control bits 29:28 are copied into status bits 29:28 if those are zero. In the next cycle one reset request pulses for one cycle: 01 gives core, 10 gives chip, 11 gives system, 00 gives none.
- R12: A watchdog event is a tick that makes time-base bit `WDT_BASE + TAP_STEP*sel` rise, where `sel` is control bits 31:30. An interval event uses `FIT_BASE + TAP_STEP*sel` with `sel` from bits 25:24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tb_tick | input | 1 | Time-base advance enable |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register index: 0 control, 1 status, 2 counter |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| pit_irq | output | 1 | Counter interrupt request |
| fit_irq | output | 1 | Interval timer interrupt request |
| wdt_irq | output | 1 | Watchdog interrupt request |
| rst_core | output | 1 | Core reset request pulse |
| rst_chip | output | 1 | Chip reset request pulse |
| rst_sys | output | 1 | System reset request pulse |

## Verification
The assertions check several rules on every cycle. Reset pulses last exactly one cycle and follow a cycle with the watchdog interrupt status set. The latched reset kind never changes once it is non-zero. Interrupt requests rise only while their enable was set. A running counter always holds a reload value above 1, and a stopped count never drifts. Only the bench scenarios can show the timing and order of the behaviours: the tick at which each period tap fires, the exact count sequence across one-shot and periodic expiries, and the three-stage watchdog escalation under every period select. They also show how control writes start and stop the counter and which status writes withdraw which requests.

// File: rtl/emb_tmr_pkg.sv
package emb_tmr_pkg;

    localparam int unsigned REG_W = 32;

    // Control register layout
    typedef struct packed {
        logic [1:0]  wdt_per;
        logic [1:0]  wdt_kind;
        logic        wdt_ie;
        logic        pit_ie;
        logic [1:0]  fit_per;
        logic        fit_ie;
        logic        pit_auto;
        logic [21:0] rsvd;
    } tcr_t;

    // Status register layout
    typedef struct packed {
        logic        wdt_next;
        logic        wdt_int;
        logic [1:0]  wdt_rs;
        logic        pit_st;
        logic        fit_st;
        logic [25:0] rsvd;
    } tsr_t;

    typedef enum logic [1:0] {
        SEL_TCR  = 2'd0,
        SEL_TSR  = 2'd1,
        SEL_PIT  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_CORE = 2'd1,
        RK_CHIP = 2'd2,
        RK_SYS  = 2'd3
    } rst_kind_e;

    localparam logic [REG_W-1:0] TCR_KEEP = 32'hFFC0_0000;
    // status bits clearable by a write; latched reset kind excluded
    localparam logic [REG_W-1:0] TSR_CLR  = 32'hCC00_0000;

    function automatic int unsigned tap_bit(int unsigned base, int unsigned step,
                                            logic [1:0] sel);
        return base + step * int'(sel);
    endfunction

    // true when the next increment makes bit b go from 0 to 1
    function automatic logic rises_next(logic [63:0] tb, int unsigned b);
        logic [63:0] low;
        low = (64'd1 << b) - 64'd1;
        return (tb & ((low << 1) | 64'd1)) == low;
    endfunction

endpackage

// File: rtl/emb_tmr_timebase.sv
module emb_tmr_timebase
    import emb_tmr_pkg::*;
#(
    parameter int unsigned TB_W     = 32,
    parameter int unsigned FIT_BASE = 9,
    parameter int unsigned WDT_BASE = 17,
    parameter int unsigned TAP_STEP = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [1:0] fit_sel,
    input  logic [1:0] wdt_sel,
    output logic       fit_evt,
    output logic       wdt_evt
);
    localparam int unsigned NTAP = 2;

    logic [TB_W-1:0] tb;
    logic [63:0]     tb64;
    logic [1:0]      sel   [NTAP];
    logic            hit   [NTAP];

    assign tb64   = 64'(tb);
    assign sel[0] = fit_sel;
    assign sel[1] = wdt_sel;

    always_ff @(posedge clk) begin
        if (rst)       tb <= '0;
        else if (tick) tb <= tb + 1'b1;
    end

    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        localparam int unsigned BASE = (t == 0) ? FIT_BASE : WDT_BASE;
        assign hit[t] = tick && rises_next(tb64, tap_bit(BASE, TAP_STEP, sel[t]));
    end

    assign fit_evt = hit[0];
    assign wdt_evt = hit[1];

    AST_EVT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (fit_evt || wdt_evt) |=> (tb == $past(tb) + 1'b1)) else $error("event without advance"); // R12

endmodule

// File: rtl/emb_tmr_pit.sv
module emb_tmr_pit #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_val,
    input  logic             ctl_wr,
    input  logic             ctl_ie_new,
    input  logic             ctl_auto_new,
    input  logic             ie_now,
    input  logic             auto_now,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic [CNT_W-1:0] reload;
    logic             run;

    assign expire = run && tick && (count == CNT_W'(1)) && !load_wr && !ctl_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload <= '0;
            count  <= '0;
            run    <= 1'b0;
        end else if (load_wr) begin
            reload <= load_val;
            count  <= load_val;
            run    <= (load_val > CNT_W'(1)) && ie_now;
        end else if (ctl_wr) begin
            if ((reload <= CNT_W'(1)) || !ctl_ie_new) begin
                run <= 1'b0;
            end else if (!run && ctl_auto_new) begin
                run   <= 1'b1;
                count <= reload;
            end
        end else if (expire) begin
            if (auto_now) begin
                count <= reload;
            end else begin
                count <= '0;
                run   <= 1'b0;
            end
        end else if (run && tick) begin
            count <= count - 1'b1;
        end
    end

    AST_PIT_RUN_RELOAD: assert property (@(posedge clk) disable iff (rst)
        run |-> (reload > CNT_W'(1))) else $error("running with short reload"); // R5
    AST_PIT_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run && !load_wr && !ctl_wr) |=> $stable(count)) else $error("stopped count moved"); // R5
    AST_PIT_ONESHOT_END: assert property (@(posedge clk) disable iff (rst)
        (expire && !auto_now) |=> (!run && count == '0)) else $error("one-shot kept running"); // R7
    AST_PIT_AUTO_KEEP: assert property (@(posedge clk) disable iff (rst)
        (expire && auto_now) |=> run) else $error("periodic counter stopped"); // R7

endmodule

// File: rtl/emb_tmr_watchdog.sv
module emb_tmr_watchdog
    import emb_tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       evt,
    input  logic       armed,
    input  logic       int_st,
    input  logic [1:0] rs_now,
    input  logic       ie,
    input  logic [1:0] kind,
    output logic       set_next,
    output logic       set_int,
    output logic       irq_req,
    output logic       rs_load,
    output logic       rst_core,
    output logic       rst_chip,
    output logic       rst_sys
);
    logic      fire;
    rst_kind_e k;

    assign k        = rst_kind_e'(kind);
    assign fire     = evt && int_st;
    assign set_next = evt && !int_st && !armed;
    assign set_int  = evt && !int_st && armed;
    assign irq_req  = set_int && ie;
    assign rs_load  = fire && (rs_now == 2'b00);

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_core <= 1'b0;
            rst_chip <= 1'b0;
            rst_sys  <= 1'b0;
        end else begin
            rst_core <= fire && (k == RK_CORE);
            rst_chip <= fire && (k == RK_CHIP);
            rst_sys  <= fire && (k == RK_SYS);
        end
    end

    AST_WDT_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
        (rst_core || rst_chip || rst_sys) |=> !(rst_core || rst_chip || rst_sys))
        else $error("reset request longer than one cycle"); // R11
    AST_WDT_FIRE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (rst_core || rst_chip || rst_sys) |-> $past(int_st))
        else $error("reset without interrupt stage"); // R11

endmodule

// File: rtl/emb_timer_unit.sv
module emb_timer_unit
    import emb_tmr_pkg::*;
#(
    parameter int unsigned TB_W     = 32,
    parameter int unsigned FIT_BASE = 9,
    parameter int unsigned WDT_BASE = 17,
    parameter int unsigned TAP_STEP = 4,
    parameter int unsigned CNT_W    = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tb_tick,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        pit_irq,
    output logic        fit_irq,
    output logic        wdt_irq,
    output logic        rst_core,
    output logic        rst_chip,
    output logic        rst_sys
);
    tcr_t             tcr, tcr_in;
    tsr_t             tsr, tsr_n;
    reg_sel_e         sel;
    logic             wr_tcr, wr_tsr, wr_pit;
    logic             fit_evt, wdt_evt;
    logic [CNT_W-1:0] pit_count;
    logic             pit_exp;
    logic             wd_next, wd_int, wd_irq, wd_rs_load;
    logic [REG_W-1:0] clr_bits;

    assign sel      = reg_sel_e'(reg_sel);
    assign wr_tcr   = reg_wr && (sel == SEL_TCR);
    assign wr_tsr   = reg_wr && (sel == SEL_TSR);
    assign wr_pit   = reg_wr && (sel == SEL_PIT);
    assign tcr_in   = tcr_t'(reg_wdata & TCR_KEEP);
    assign clr_bits = wr_tsr ? (reg_wdata & TSR_CLR) : '0;

    emb_tmr_timebase #(
        .TB_W(TB_W), .FIT_BASE(FIT_BASE), .WDT_BASE(WDT_BASE), .TAP_STEP(TAP_STEP)
    ) u_tb (
        .clk(clk), .rst(rst), .tick(tb_tick),
        .fit_sel(tcr.fit_per), .wdt_sel(tcr.wdt_per),
        .fit_evt(fit_evt), .wdt_evt(wdt_evt)
    );

    emb_tmr_pit #(.CNT_W(CNT_W)) u_pit (
        .clk(clk), .rst(rst), .tick(tb_tick),
        .load_wr(wr_pit), .load_val(reg_wdata[CNT_W-1:0]),
        .ctl_wr(wr_tcr), .ctl_ie_new(tcr_in.pit_ie), .ctl_auto_new(tcr_in.pit_auto),
        .ie_now(tcr.pit_ie), .auto_now(tcr.pit_auto),
        .count(pit_count), .expire(pit_exp)
    );

    emb_tmr_watchdog u_wdt (
        .clk(clk), .rst(rst), .evt(wdt_evt),
        .armed(tsr.wdt_next), .int_st(tsr.wdt_int), .rs_now(tsr.wdt_rs),
        .ie(tcr.wdt_ie), .kind(tcr.wdt_kind),
        .set_next(wd_next), .set_int(wd_int), .irq_req(wd_irq), .rs_load(wd_rs_load),
        .rst_core(rst_core), .rst_chip(rst_chip), .rst_sys(rst_sys)
    );

    // status next state: clears first, new events win
    always_comb begin
        tsr_n = tsr_t'(tsr & ~clr_bits);
        if (fit_evt)    tsr_n.fit_st   = 1'b1;
        if (pit_exp)    tsr_n.pit_st   = 1'b1;
        if (wd_next)    tsr_n.wdt_next = 1'b1;
        if (wd_int)     tsr_n.wdt_int  = 1'b1;
        if (wd_rs_load) tsr_n.wdt_rs   = tcr.wdt_kind;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tcr     <= '0;
            tsr     <= '0;
            pit_irq <= 1'b0;
            fit_irq <= 1'b0;
            wdt_irq <= 1'b0;
        end else begin
            if (wr_tcr) tcr <= tcr_in;
            tsr <= tsr_n;
            if (fit_evt && tcr.fit_ie)    fit_irq <= 1'b1;
            else if (clr_bits[26])        fit_irq <= 1'b0;
            if (pit_exp && tcr.pit_ie)    pit_irq <= 1'b1;
            else if (clr_bits[31])        pit_irq <= 1'b0;
            if (wd_irq)                   wdt_irq <= 1'b1;
            else if (clr_bits[30])        wdt_irq <= 1'b0;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_TCR: reg_rdata = tcr;
            SEL_TSR: reg_rdata = tsr;
            SEL_PIT: reg_rdata = REG_W'(pit_count);
            default: reg_rdata = '0;
        endcase
    end

    AST_TCR_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        tcr.rsvd == '0) else $error("control low bits set"); // R2
    AST_RS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (tsr.wdt_rs != 2'b00) |=> $stable(tsr.wdt_rs)) else $error("latched kind changed"); // R3
    AST_FIT_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(fit_irq) |-> ($past(tcr.fit_ie) && tsr.fit_st)) else $error("interval irq ungated"); // R4
    AST_PIT_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(pit_irq) |-> ($past(tcr.pit_ie) && tsr.pit_st)) else $error("counter irq ungated"); // R6
    AST_PIT_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
        $fell(pit_irq) |-> ($past(wr_tsr) && $past(reg_wdata[31]))) else $error("counter irq lost"); // R8
    AST_WDT_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_irq) |-> ($past(tcr.wdt_ie) && tsr.wdt_int)) else $error("watchdog irq ungated"); // R10

endmodule

// File: tb/emb_timer_unit_tb.sv
module emb_timer_unit_tb_top;

    localparam int unsigned TB_W = 16;
    localparam int unsigned FB   = 1;
    localparam int unsigned WB   = 3;
    localparam int unsigned ST   = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tb_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pit_irq, fit_irq, wdt_irq, rst_core, rst_chip, rst_sys;

    int          n_chk = 0;
    int          n_bad = 0;
    int unsigned tbm = 0;
    // watchdog model
    logic        en_m = 0, wis_m = 0, wirq_m = 0;
    logic [1:0]  rs_m = 0;
    // counter model
    int unsigned c_m = 0, rel_m = 0;
    logic        run_m = 0, pie_m = 0, auto_m = 0, pst_m = 0, pirq_m = 0;

    always #4 clk = ~clk;

    emb_timer_unit #(
        .TB_W(TB_W), .FIT_BASE(FB), .WDT_BASE(WB), .TAP_STEP(ST), .CNT_W(32)
    ) dut_i (
        .clk(clk), .rst(rst), .tb_tick(tb_tick), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pit_irq(pit_irq), .fit_irq(fit_irq), .wdt_irq(wdt_irq),
        .rst_core(rst_core), .rst_chip(rst_chip), .rst_sys(rst_sys)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic due(input int unsigned tb, input int unsigned b);
        int unsigned low;
        low = (32'd1 << b) - 1;
        return (tb & ((low << 1) | 1)) == low;
    endfunction

    task automatic tick();
        tb_tick = 1'b1;
        @(posedge clk); #1;
        tb_tick = 1'b0;
        tbm++;
    endtask

    task automatic wr(input logic [1:0] s, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] v);
        reg_sel = s; #1;
        v = reg_rdata;
    endtask

    task automatic fit_sweep(input logic [1:0] s, input logic ie, input int n);
        logic [31:0] v;
        wr(2'd0, (32'(s) << 24) | (32'(ie) << 23));
        wr(2'd1, 32'h0400_0000);
        for (int i = 0; i < n; i++) begin
            logic e;
            e = due(tbm, FB + ST * s);
            tick();
            rd(2'd1, v);
            check("R4/R12 interval status", 32'(v[26]), 32'(e));
            check("R4 interval irq", 32'(fit_irq), 32'(e && ie));
            if (e) begin
                wr(2'd1, 32'h0400_0000);
                check("R4 interval irq clear", 32'(fit_irq), 32'd0);
            end
        end
    endtask

    task automatic wdt_run(input logic [1:0] s, input logic [1:0] kind, input logic ie, input int n);
        logic [31:0] v;
        wr(2'd0, (32'(s) << 30) | (32'(kind) << 28) | (32'(ie) << 27));
        for (int i = 0; i < n; i++) begin
            logic e, fire;
            logic [2:0] rexp;
            e    = due(tbm, WB + ST * s);
            fire = e && wis_m;
            rexp = 3'b000;
            if (fire && kind != 2'd0) rexp = 3'b001 << (kind - 2'd1);
            if (fire && rs_m == 2'd0) rs_m = kind;
            if (e && !wis_m && en_m) begin
                wis_m = 1'b1;
                if (ie) wirq_m = 1'b1;
            end else if (e && !wis_m) begin
                en_m = 1'b1;
            end
            tick();
            rd(2'd1, v);
            check("R10/R12 watchdog stage", 32'(v[31:30]), 32'({en_m, wis_m}));
            check("R11 latched kind", 32'(v[29:28]), 32'(rs_m));
            check("R11 reset pulse", 32'({rst_sys, rst_chip, rst_core}), 32'(rexp));
            check("R10 watchdog irq", 32'(wdt_irq), 32'(wirq_m));
        end
    endtask

    task automatic wdt_clear();
        wr(2'd1, 32'hC000_0000);
        en_m = 0; wis_m = 0; wirq_m = 0;
    endtask

    task automatic pit_set_tcr(input logic ie, input logic au);
        wr(2'd0, (32'(ie) << 26) | (32'(au) << 22));
        if (rel_m <= 1 || !ie) run_m = 0;
        else if (!run_m && au) begin run_m = 1; c_m = rel_m; end
        pie_m = ie; auto_m = au;
    endtask

    task automatic pit_load(input int unsigned val);
        wr(2'd2, val);
        rel_m = val; c_m = val; run_m = (val > 1) && pie_m;
    endtask

    task automatic pit_run(input int n, input string req);
        logic [31:0] v;
        for (int i = 0; i < n; i++) begin
            if (run_m) begin
                if (c_m == 1) begin
                    pst_m = 1;
                    if (pie_m) pirq_m = 1;
                    if (auto_m) c_m = rel_m;
                    else begin c_m = 0; run_m = 0; end
                end else c_m--;
            end
            tick();
            rd(2'd2, v);
            check({req, " count"}, v, c_m);
            rd(2'd1, v);
            check("R6 counter status", 32'(v[27]), 32'(pst_m));
            check("R6 counter irq", 32'(pit_irq), 32'(pirq_m));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog timeout act=hung exp=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(2'd0, v); check("R1 control", v, 32'h0);
        rd(2'd1, v); check("R1 status", v, 32'h0);
        rd(2'd2, v); check("R1 count", v, 32'h0);
        check("R1 outputs", 32'({pit_irq, fit_irq, wdt_irq, rst_core, rst_chip, rst_sys}), 32'h0);

        // R2 control mask
        wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, v); check("R2 mask high", v, 32'hFFC0_0000);
        wr(2'd0, 32'h003F_FFFF); rd(2'd0, v); check("R2 mask low", v, 32'h0);
        wr(2'd0, 32'h1234_5678); rd(2'd0, v); check("R2 mask mix", v, 32'h1200_0000);
        wr(2'd0, 32'h0);

        // R4 interval timer across all period selects
        for (int s = 0; s < 4; s++) fit_sweep(2'(s), 1'b1, 64);
        fit_sweep(2'd0, 1'b0, 12);

        // R10 R11 R12 watchdog stages under each period select, no reset kind
        for (int s = 0; s < 4; s++) begin
            wdt_clear();
            wdt_run(2'(s), 2'd0, s[0], 4 << (WB + 1 + s));
        end
        wdt_clear();
        wdt_run(2'd0, 2'd0, 1'b1, 40);
        check("R10 irq raised", 32'(wdt_irq), 32'd1);
        wr(2'd1, 32'h4000_0000);
        rd(2'd1, v);
        check("R10 irq withdrawn", 32'(wdt_irq), 32'd0);
        check("R10 int bit cleared", 32'(v[30]), 32'd0);
        check("R10 next bit kept", 32'(v[31]), 32'd1);

        // R11 R3 reset kind latches and sticks
        wdt_clear();
        wdt_run(2'd0, 2'd1, 1'b0, 64);
        check("R11 core kind latched", 32'(rs_m), 32'd1);
        wr(2'd1, 32'hFC00_0000);
        rd(2'd1, v);
        check("R3 kind not clearable", 32'(v[29:28]), 32'd1);
        check("R3 w1c others", 32'({v[31:30], v[27:26]}), 32'd0);
        en_m = 0; wis_m = 0; wirq_m = 0;
        wdt_run(2'd0, 2'd3, 1'b1, 64);
        wdt_clear();
        wdt_run(2'd0, 2'd2, 1'b0, 64);

        // counter one-shot, R5 R6 R7
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h8800_0000);
        pst_m = 0; pirq_m = 0; run_m = 0;
        pit_set_tcr(1'b1, 1'b0);
        pit_load(5);
        rd(2'd2, v); check("R5 load readback", v, 32'd5);
        pit_run(9, "R7 one-shot");

        // R8 withdraw rules
        wr(2'd1, 32'h0800_0000); pst_m = 0;
        rd(2'd1, v);
        check("R8 status27 cleared", 32'(v[27]), 32'd0);
        check("R8 irq kept", 32'(pit_irq), 32'd1);
        wr(2'd1, 32'h8000_0000); pirq_m = 0;
        check("R8 irq withdrawn", 32'(pit_irq), 32'd0);

        // R7 periodic sweep of reload values
        pit_set_tcr(1'b1, 1'b1);
        for (int r = 2; r < 10; r++) begin
            pit_load(32'(r));
            pit_run(3 * r + 1, "R7 periodic");
            wr(2'd1, 32'h8800_0000); pst_m = 0; pirq_m = 0;
        end

        // R5 short reload stays stopped
        pit_load(1);
        pit_run(4, "R5 reload one");
        pit_load(0);
        pit_run(3, "R5 reload zero");

        // R5 R9 enable gating and control-write start/stop
        pit_set_tcr(1'b0, 1'b0);
        pit_load(4);
        pit_run(3, "R5 disabled hold");
        pit_set_tcr(1'b1, 1'b0);
        pit_run(2, "R9 no restart without auto");
        pit_set_tcr(1'b1, 1'b1);
        pit_run(2, "R9 restart");
        rd(2'd2, v); check("R9 running value", v, 32'd2);
        pit_set_tcr(1'b0, 1'b1);
        pit_run(3, "R9 stop hold");
        rd(2'd2, v); check("R9 held value", v, 32'd2);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule